// File: doc/BRIEF.md
# SPI Slave Port with Idle-Pattern Filtering

This block is a slave-mode SPI port for an embedded receiver. A host exchanges bytes with it over four pins. There is a clock, an active-low select, a data input and a data output. Local software reaches the port through a simple register-side bus. On that bus it loads a transmit FIFO, drains a receive FIFO and sets thresholds and idle patterns. Both directions shift at the same time on every byte. Nothing has to be armed before a receive. The host polls by clocking bytes out whenever it likes.

Idle traffic is handled in both directions:

- **Transmit.** When the transmit side has nothing to send, the port sends a programmable two-byte idle pattern. The host reads that pattern as "no more data". Once the last queued byte leaves, the transmit FIFO disables itself. Software must enable it again after it refills the FIFO.
- **Receive.** The port compares incoming bytes with its own two-byte idle pattern. After a programmed number of complete pattern repeats, it stops storing them. Storage resumes with the first byte that breaks the pattern.

Interrupt outputs report programmable fill levels, an empty-and-disabled transmit FIFO, and a select released in the middle of a byte.

The serial pins are oversampled in the system clock domain through a short synchroniser chain. The port therefore needs a system clock several times faster than the serial clock.

Top module: `spi_idle_slave`

## Requirements
- R1: Transfers use clock mode 0 with the most significant bit first. The port samples `mosi` on each rising `sck` edge and changes `miso` after each falling edge while `cs_n` is low. Every eight rising edges form one received byte. No enable is needed for reception.
- R2: Bytes written with `tx_push` leave on `miso` in write order. A push to a full transmit FIFO is ignored. `tx_count` gives the current fill.
- R3: The port sends idle bytes when the transmit FIFO is disabled or empty.
  - Idle bytes alternate: `tx_idle[15:8]` first, then `tx_idle[7:0]`.
  - The alternation restarts at `tx_idle[15:8]` after any FIFO byte is sent and after `port_clear`.
  - The FIFO disables itself when its last byte is taken. It also disables itself when a byte is needed while it is enabled but empty. A one-cycle `tx_start` pulse enables it.
- R4: The port prepares the next outgoing byte ahead of its first bit. If select is released before that byte's first bit is sampled, the byte is kept. It is then the first byte of the next selection.
- R5: The receive filter stores bytes until it has seen `rx_limit` complete pairs of `rx_idle[15:8]` followed by `rx_idle[7:0]`. The bytes that complete the count are stored. After that, bytes that continue the alternating pattern are dropped. The first byte that breaks the pattern is stored and restarts the count at zero.
- R6: An `rx_limit` of zero turns the filter off, so every received byte is stored.
- R7: A received byte that finds the receive FIFO full is lost. `rx_data` shows the oldest stored byte, and `rx_pop` removes it. `rx_count` gives the fill.
- R8: `irq_tx_level` is high while `tx_count <= tx_thr`. `irq_rx_level` is high while `rx_count >= rx_thr`.
- R9: `irq_tx_empty` is high exactly while the transmit FIFO is both empty and disabled.
- R10: Releasing select after one to seven bits of a byte discards the partial byte and sets `irq_sync_err`. The flag stays set until `port_clear`.
- R11: A `port_clear` pulse flushes both FIFOs. It also disables transmit, drops the prepared byte, restarts both idle sequences and the repeat count, and clears `irq_sync_err`.
- R12: After reset both FIFOs are empty, transmit is disabled, `irq_tx_empty` is high and `irq_sync_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_clear | input | 1 | Software reset of the port (one-cycle pulse) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Serial data into the port |
| miso | output | 1 | Serial data out of the port (low while deselected) |
| tx_push | input | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_start | input | 1 | Enable the transmit FIFO |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| tx_idle | input | 16 | Transmit idle pair, high byte sent first |
| rx_idle | input | 16 | Receive idle pair, high byte expected first |
| rx_limit | input | LIMIT_W | Pattern repeats before suppression, 0 = off |
| tx_thr | input | CW | Transmit low-fill threshold |
| rx_thr | input | CW | Receive fill threshold |
| tx_count | output | CW | Transmit FIFO fill |
| rx_count | output | CW | Receive FIFO fill |
| irq_tx_level | output | 1 | Transmit fill at or below threshold |
| irq_rx_level | output | 1 | Receive fill at or above threshold |
| irq_tx_empty | output | 1 | Transmit FIFO empty and disabled |
| irq_sync_err | output | 1 | Select released mid-byte (sticky) |

## Verification
The bench builds the port with a FIFO depth of 8, a two-stage synchroniser and a 4-bit repeat limit. The shallow FIFOs let a single selection overrun the receive side, so byte loss on a full FIFO can be checked, and ten pushes hit the transmit full boundary. With the small limit field, a repeat limit of 2 is reached inside one short selection, so both the suppression and the pattern break are exercised. The serial clock runs at one sixteenth of the system clock, which leaves each synchronised edge settled before the bench samples `miso`.

// File: rtl/spi_idle_pkg.sv
package spi_idle_pkg;
   typedef logic [7:0] byte_t;
   typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} idle_phase_e;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sif_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/sif_fifo.sv
module sif_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sif_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   assign dout = mem[rp];
endmodule

// File: rtl/sif_shift_engine.sv
module sif_shift_engine
   import spi_idle_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  sck_s,
   input  logic  cs_act,
   input  logic  mosi_s,
   input  byte_t load_byte,
   output logic  load_req,
   output logic  rx_valid,
   output byte_t rx_byte,
   output logic  sync_err,
   output logic  miso
);
   byte_t      tx_sr, rx_sr;
   logic [2:0] bit_cnt;
   logic       sck_q, act_q, staged, need_load;
   logic       rise, fall, start, stop;

   assign rise  = cs_act && sck_s && !sck_q;
   assign fall  = cs_act && !sck_s && sck_q;
   assign start = cs_act && !act_q;
   assign stop  = !cs_act && act_q;

   assign load_req = (start && !staged) || (fall && need_load);
   assign rx_valid = rise && (bit_cnt == 3'd7);
   assign rx_byte  = {rx_sr[6:0], mosi_s};
   assign sync_err = stop && (bit_cnt != 3'd0);
   assign miso     = cs_act ? tx_sr[7] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         act_q     <= 1'b0;
         tx_sr     <= '0;
         rx_sr     <= '0;
         bit_cnt   <= '0;
         staged    <= 1'b0;
         need_load <= 1'b0;
      end else begin
         sck_q <= sck_s;
         act_q <= cs_act;
         if (clr) begin
            tx_sr     <= '0;
            rx_sr     <= '0;
            bit_cnt   <= '0;
            staged    <= 1'b0;
            need_load <= 1'b0;
         end else begin
            if (load_req) begin
               tx_sr     <= load_byte;
               staged    <= 1'b1;
               need_load <= 1'b0;
            end else if (fall && bit_cnt != 3'd0) begin
               tx_sr <= {tx_sr[6:0], 1'b0};
            end
            if (rise) begin
               rx_sr   <= {rx_sr[6:0], mosi_s};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd0) staged    <= 1'b0;
               if (bit_cnt == 3'd7) need_load <= 1'b1;
            end
            if (stop) begin
               bit_cnt   <= '0;
               need_load <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sif_rx_filter.sv
module sif_rx_filter
   import spi_idle_pkg::*;
#(
   parameter int LIMIT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               in_valid,
   input  byte_t              in_byte,
   input  logic [15:0]        idle_pat,
   input  logic [LIMIT_W-1:0] limit,
   output logic               wr_en
);
   idle_phase_e        phase;
   logic [LIMIT_W-1:0] reps;
   logic               hi_hit, lo_hit, suppress, exp_hit;

   assign hi_hit   = (in_byte == idle_pat[15:8]);
   assign lo_hit   = (in_byte == idle_pat[7:0]);
   assign suppress = (limit != '0) && (reps == limit);
   assign exp_hit  = (phase == PH_LO) ? lo_hit : hi_hit;
   assign wr_en    = in_valid && !(suppress && exp_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_HI;
         reps  <= '0;
      end else if (clr) begin
         phase <= PH_HI;
         reps  <= '0;
      end else if (in_valid) begin
         if (suppress && exp_hit) begin
            phase <= (phase == PH_HI) ? PH_LO : PH_HI;
         end else if (phase == PH_HI && hi_hit) begin
            phase <= PH_LO;
         end else if (phase == PH_LO && lo_hit) begin
            phase <= PH_HI;
            if (reps != limit) reps <= reps + LIMIT_W'(1);
         end else begin
            reps  <= '0;
            phase <= hi_hit ? PH_LO : PH_HI;
         end
      end
   end
endmodule

// File: rtl/spi_idle_slave.sv
module spi_idle_slave
   import spi_idle_pkg::*;
#(
   parameter int DEPTH       = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int LIMIT_W     = 8,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               port_clear,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               miso,
   input  logic               tx_push,
   input  logic [7:0]         tx_data,
   input  logic               tx_start,
   input  logic               rx_pop,
   output logic [7:0]         rx_data,
   input  logic [15:0]        tx_idle,
   input  logic [15:0]        rx_idle,
   input  logic [LIMIT_W-1:0] rx_limit,
   input  logic [CW-1:0]      tx_thr,
   input  logic [CW-1:0]      rx_thr,
   output logic [CW-1:0]      tx_count,
   output logic [CW-1:0]      rx_count,
   output logic               irq_tx_level,
   output logic               irq_rx_level,
   output logic               irq_tx_empty,
   output logic               irq_sync_err
);
   if (LIMIT_W < 1) begin : g_bad_limit
      $error("spi_idle_slave: LIMIT_W must be at least 1");
   end

   // pin order: [2] sck, [1] cs_n, [0] mosi
   localparam logic [2:0] PIN_RST = 3'b010;
   logic [2:0] pin_raw, pin_sync;
   assign pin_raw = {sck, cs_n, mosi};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      sif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_sync[g])
      );
   end

   logic  load_req, rx_valid, sync_err, rx_wr;
   byte_t load_byte, rx_byte, tx_head;
   logic  tx_en, tx_empty, tx_take, err_flag;
   idle_phase_e idle_ph;

   sif_shift_engine u_eng (
      .clk(clk), .rst_n(rst_n), .clr(port_clear),
      .sck_s(pin_sync[2]), .cs_act(!pin_sync[1]), .mosi_s(pin_sync[0]),
      .load_byte(load_byte), .load_req(load_req),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .sync_err(sync_err), .miso(miso)
   );

   assign tx_empty  = (tx_count == '0);
   assign tx_take   = load_req && tx_en && !tx_empty;
   assign load_byte = tx_take ? tx_head
                    : ((idle_ph == PH_LO) ? tx_idle[7:0] : tx_idle[15:8]);

   sif_fifo #(.W(8), .DEPTH(DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .clr(port_clear),
      .push(tx_push), .din(tx_data), .pop(tx_take),
      .dout(tx_head), .count(tx_count)
   );

   sif_rx_filter #(.LIMIT_W(LIMIT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .clr(port_clear),
      .in_valid(rx_valid), .in_byte(rx_byte),
      .idle_pat(rx_idle), .limit(rx_limit), .wr_en(rx_wr)
   );

   sif_fifo #(.W(8), .DEPTH(DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(port_clear),
      .push(rx_wr), .din(rx_byte), .pop(rx_pop),
      .dout(rx_data), .count(rx_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en    <= 1'b0;
         idle_ph  <= PH_HI;
         err_flag <= 1'b0;
      end else if (port_clear) begin
         tx_en    <= 1'b0;
         idle_ph  <= PH_HI;
         err_flag <= 1'b0;
      end else begin
         if (load_req) begin
            if (tx_take) begin
               idle_ph <= PH_HI;
               if (tx_count == CW'(1) && !tx_push) tx_en <= 1'b0;
            end else begin
               idle_ph <= (idle_ph == PH_HI) ? PH_LO : PH_HI;
               tx_en   <= 1'b0;
            end
         end
         if (tx_start) tx_en <= 1'b1;
         if (sync_err) err_flag <= 1'b1;
      end
   end

   assign irq_tx_level = (tx_count <= tx_thr);
   assign irq_rx_level = (rx_count >= rx_thr);
   assign irq_tx_empty = tx_empty && !tx_en;
   assign irq_sync_err = err_flag;
endmodule

// File: rtl/sif_checker.sv
module sif_checker #(
   parameter int DEPTH = 1024,
   parameter int CW    = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          port_clear,
   input logic          cs_n,
   input logic          tx_push,
   input logic          tx_start,
   input logic [CW-1:0] tx_count,
   input logic [CW-1:0] rx_count,
   input logic          irq_tx_empty,
   input logic          irq_sync_err
);
   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age <= '0;
      else if (age != 3'd7)   age <= age + 3'd1;
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH))); // R2

   AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd1) |-> ({1'b0, rx_count} <= {1'b0, $past(rx_count)} + 1'b1)); // R7

   AST_RX_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd6 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> (rx_count <= $past(rx_count))); // R1

   AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      port_clear |=> (tx_count == '0) && (rx_count == '0) && !irq_sync_err); // R11

   AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sync_err && !port_clear) |=> irq_sync_err); // R10

   AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_count == '0 && !port_clear) |=> !irq_tx_empty); // R9

   AST_START_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && !port_clear) |=> !irq_tx_empty); // R9
endmodule

bind spi_idle_slave sif_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .port_clear(port_clear), .cs_n(cs_n),
   .tx_push(tx_push), .tx_start(tx_start),
   .tx_count(tx_count), .rx_count(rx_count),
   .irq_tx_empty(irq_tx_empty), .irq_sync_err(irq_sync_err)
);

// File: tb/sim_spi_idle_slave.sv
module sim_spi_idle_slave;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int CW         = $clog2(DEPTH + 1);
   localparam int LW         = 4;
   localparam int HALF       = 8;
   localparam int TXTHR      = 2;
   localparam int RXTHR      = 3;
   localparam logic [15:0] TXI = 16'hC33C;
   localparam logic [15:0] RXI = 16'h7E81;

   logic clk = 1'b0, rst_n = 1'b0, port_clear = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
   logic tx_push = 1'b0, tx_start = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_data = '0, rx_data;
   logic [LW-1:0] rx_limit = LW'(2);
   logic [CW-1:0] tx_count, rx_count;
   logic irq_tx_level, irq_rx_level, irq_tx_empty, irq_sync_err;

   spi_idle_slave #(.DEPTH(DEPTH), .SYNC_STAGES(2), .LIMIT_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .port_clear(port_clear),
      .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .tx_push(tx_push), .tx_data(tx_data), .tx_start(tx_start),
      .rx_pop(rx_pop), .rx_data(rx_data),
      .tx_idle(TXI), .rx_idle(RXI), .rx_limit(rx_limit),
      .tx_thr(CW'(TXTHR)), .rx_thr(CW'(RXTHR)),
      .tx_count(tx_count), .rx_count(rx_count),
      .irq_tx_level(irq_tx_level), .irq_rx_level(irq_rx_level),
      .irq_tx_empty(irq_tx_empty), .irq_sync_err(irq_sync_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // behavioural reference model
   logic [7:0] m_txq[$];
   logic [7:0] m_rxq[$];
   bit m_tx_en = 0, m_idle_lo = 0, m_staged = 0, m_err = 0, m_ph_lo = 0;
   logic [7:0] m_stage = '0;
   int m_reps = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_next();
      logic [7:0] v;
      if (m_tx_en && m_txq.size() > 0) begin
         v = m_txq.pop_front();
         m_idle_lo = 0;
         if (m_txq.size() == 0) m_tx_en = 0;
      end else begin
         v = m_idle_lo ? TXI[7:0] : TXI[15:8];
         m_idle_lo = !m_idle_lo;
         m_tx_en = 0;
      end
      return v;
   endfunction

   task automatic m_rx(input logic [7:0] b);
      bit hi, lo, sup, eh;
      hi  = (b == RXI[15:8]);
      lo  = (b == RXI[7:0]);
      sup = (rx_limit != 0) && (m_reps == int'(rx_limit));
      eh  = m_ph_lo ? lo : hi;
      if (!(sup && eh) && m_rxq.size() < DEPTH) m_rxq.push_back(b);
      if (sup && eh) m_ph_lo = !m_ph_lo;
      else if (!m_ph_lo && hi) m_ph_lo = 1;
      else if (m_ph_lo && lo) begin
         m_ph_lo = 0;
         if (m_reps != int'(rx_limit)) m_reps++;
      end else begin
         m_reps = 0;
         m_ph_lo = hi;
      end
   endtask

   task automatic check_state(input string tag);
      check({tag, " R2 tx_count"}, 32'(tx_count), 32'(m_txq.size()));
      check({tag, " R7 rx_count"}, 32'(rx_count), 32'(m_rxq.size()));
      check({tag, " R9 irq_tx_empty"}, 32'(irq_tx_empty), 32'(m_txq.size() == 0 && !m_tx_en));
      check({tag, " R10 irq_sync_err"}, 32'(irq_sync_err), 32'(m_err));
      check({tag, " R8 irq_tx_level"}, 32'(irq_tx_level), 32'(m_txq.size() <= TXTHR));
      check({tag, " R8 irq_rx_level"}, 32'(irq_rx_level), 32'(m_rxq.size() >= RXTHR));
   endtask

   task automatic cs_on();
      @(negedge clk) cs_n = 1'b0;
      if (!m_staged) begin
         m_stage  = m_next();
         m_staged = 1;
      end
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_off(input bit partial);
      @(negedge clk) cs_n = 1'b1;
      if (partial) m_err = 1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] mo, input int nbits);
      logic [7:0] got, exp;
      got = '0;
      exp = m_stage;
      for (int i = 0; i < nbits; i++) begin
         mosi = mo[7-i];
         repeat (HALF) @(negedge clk);
         got[7-i] = miso;
         sck = 1'b1;
         if (i == 0) m_staged = 0;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      if (nbits == 8) begin
         check("R1 R3 R4 miso byte", 32'(got), 32'(exp));
         m_rx(mo);
         m_stage  = m_next();
         m_staged = 1;
      end
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk) begin tx_push = 1'b1; tx_data = d; end
      @(negedge clk) tx_push = 1'b0;
      if (m_txq.size() < DEPTH) m_txq.push_back(d);
   endtask

   task automatic start_tx();
      @(negedge clk) tx_start = 1'b1;
      @(negedge clk) tx_start = 1'b0;
      m_tx_en = 1;
   endtask

   task automatic drain(input string tag);
      while (m_rxq.size() > 0) begin
         @(negedge clk);
         check({tag, " R7 rx_data"}, 32'(rx_data), 32'(m_rxq.pop_front()));
         rx_pop = 1'b1;
         @(negedge clk) rx_pop = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic clear_port();
      @(negedge clk) port_clear = 1'b1;
      @(negedge clk) port_clear = 1'b0;
      m_txq.delete(); m_rxq.delete();
      m_tx_en = 0; m_idle_lo = 0; m_staged = 0; m_err = 0; m_ph_lo = 0; m_reps = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_state("R12 reset");

      // idle bytes while transmit is disabled
      cs_on();
      xfer(8'h11, 8); xfer(8'h22, 8); xfer(8'h33, 8);
      cs_off(0);
      check_state("R1 R3 idle session");
      drain("R1");

      // queued bytes, held byte first
      push(8'hAA); push(8'hBB); push(8'hCC);
      check_state("R2 queued");
      start_tx();
      check_state("R9 enabled");
      cs_on();
      for (int k = 1; k <= 5; k++) xfer(8'(k), 8);
      cs_off(0);
      check_state("R3 R4 after data");
      drain("R2");

      // receive filter, limit 2
      cs_on();
      xfer(8'h7E, 8); xfer(8'h81, 8); xfer(8'h7E, 8); xfer(8'h81, 8);
      xfer(8'h7E, 8); xfer(8'h81, 8); xfer(8'h7E, 8); xfer(8'h55, 8);
      cs_off(0);
      check("R5 filtered count", 32'(rx_count), 32'd5);
      check_state("R5 filter");
      drain("R5");

      // partial byte
      cs_on();
      xfer(8'hF0, 3);
      cs_off(1);
      check_state("R10 sync error");
      cs_on();
      xfer(8'h42, 8);
      cs_off(0);
      check_state("R10 sticky");
      drain("R10");

      // receive overrun
      cs_on();
      for (int k = 0; k < 10; k++) xfer(8'h20 + 8'(k), 8);
      cs_off(0);
      check("R7 rx full", 32'(rx_count), 32'(DEPTH));
      check_state("R7 overrun");
      drain("R7");

      // transmit full
      for (int k = 0; k < 10; k++) push(8'h90 + 8'(k));
      check("R2 tx full", 32'(tx_count), 32'(DEPTH));
      check_state("R2 full");

      // software clear
      clear_port();
      check_state("R11 clear");
      check("R11 irq_tx_empty", 32'(irq_tx_empty), 32'd1);

      // filter off
      rx_limit = '0;
      cs_on();
      for (int k = 0; k < 3; k++) begin xfer(8'h7E, 8); xfer(8'h81, 8); end
      cs_off(0);
      check("R6 unfiltered count", 32'(rx_count), 32'd6);
      check_state("R6 filter off");
      drain("R6");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule